// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block steps a multi-word load or store through memory one word per cycle. A start pulse supplies a 32-bit base value, a 16-bit register mask, a direction, a before/after option and a writeback enable. The block then spends one setup cycle. After that it presents one word address and one register index on each cycle, in order. While a sequence runs, the start input has no effect.

The address legality check covers only the first word. Every later address is formed modulo 2^26 and never raises an exception. The writeback value of the base is presented during the first transfer beat and takes effect at the end of that beat, which is the second cycle of the operation. Because of this, a stored copy of the base holds the old value when the base is the first register transferred and the updated value when it comes later. The block flags that case.

A coprocessor-load option appends one extra beat after the last requested word, which reads the next address and marks its data for discard. An empty mask finishes in the setup cycle, with no memory beat and no writeback. The memory port and the register file are outside this block.

Top module: `blk_xfer_seq`

## Requirements
- R1: On the first transfer beat only, `addr_exc` is 1 exactly when the first address, computed in full 32-bit arithmetic before truncation, is 0x04000000 or above.
- R2: Beats after the first never raise `addr_exc`, and their addresses wrap modulo 2^26; for example, base 0x03FFFFFC, ascending, after, two words gives a second address of 0x0000000.
- R3: With n set bits in the mask, the first address is base (up, after), base+4 (up, before), base-4n+4 (down, after) or base-4n (down, before), and each later beat adds 4.
- R4: The cycle after start is a setup cycle with `busy`=1 and no beat. The first beat comes in the second cycle, and `wb_valid` is 1 on that beat only, and only when writeback is enabled.
- R5: `wb_value` on the writeback beat equals base+4n (up) or base-4n (down), truncated to 26 bits.
- R6: Registers are presented in ascending index order, one per beat: the lowest set mask bit goes with the lowest address.
- R7: `store_new_base` is 1 on a beat exactly when writeback is enabled, the beat's register equals `base_reg`, and the beat is not the first one.
- R8: On the writeback beat, `wb_user_bank` equals the `force_user` value given at start. The base is read from the current bank but written to the user bank.
- R9: With `cop_load`=1 and a non-empty mask, one extra beat follows the last requested word, with `xfer_discard`=1, the next address (modulo 2^26), and `done`=1.
- R10: An empty mask gives `done`=1 in the setup cycle, then idle, with no beat and no writeback.
- R11: A start pulse while `busy` is 1 is ignored. The running sequence's outputs are unchanged.
- R12: After reset, `busy`, `xfer_valid`, `wb_valid`, `addr_exc` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| base | input | 32 | Base register value |
| reg_mask | input | 16 | Register list, bit i selects register i |
| dir_up | input | 1 | 1 ascending addresses, 0 descending |
| pre_step | input | 1 | 1 step before the first access, 0 after |
| wb_en | input | 1 | Write the updated base back |
| force_user | input | 1 | Transfer targets the user bank |
| cop_load | input | 1 | Coprocessor load with one trailing over-fetch |
| base_reg | input | 4 | Index of the base register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of the operation |
| xfer_valid | output | 1 | A memory beat this cycle |
| xfer_addr | output | 26 | Word address of the beat |
| xfer_reg | output | 4 | Register index of the beat |
| xfer_discard | output | 1 | Over-fetch beat, data discarded |
| addr_exc | output | 1 | Address exception on the first beat |
| store_new_base | output | 1 | Stored base takes the updated value |
| wb_valid | output | 1 | Base writeback at the end of this cycle |
| wb_value | output | 26 | Updated base value |
| wb_user_bank | output | 1 | Writeback goes to the user bank |

## Verification
A stale remaining-mask register would show up on the next beat as a repeated or skipped register index, or as a beat count that does not match the population count. A wrong address register would put every later address off by a constant from its first wrong beat onward. A misplaced first-beat flag would move the exception, the writeback strobe and the old/new base choice by one beat. This is visible in the second cycle of the operation. The bench compares every beat of every operation against addresses and indices computed arithmetically, so each of these faults is caught on the beat where it first occurs.

// File: rtl/blkx_pkg.sv
// Shared types and helpers for the block transfer address sequencer.
// Assumes the register mask is at most 32 bits wide.
package blkx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_BEAT  = 2'd2,
        ST_OVER  = 2'd3
    } seq_state_t;

    // Count set bits of a mask (loop unrolls to an adder tree).
    function automatic int unsigned ones_in(input logic [31:0] m);
        int unsigned c;
        c = 0;
        for (int i = 0; i < 32; i++) c += int'(m[i]);
        return c;
    endfunction
endpackage

// File: rtl/blkx_plan.sv
// Start-of-operation planner: from base, mask and mode it computes the
// full-width first address, its legality, and the truncated writeback value.
// Assumes purely combinational use at the start pulse.
module blkx_plan #(
    parameter int REGS   = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 26
) (
    input  logic [DATA_W-1:0] base,
    input  logic [REGS-1:0]   mask,
    input  logic              dir_up,
    input  logic              pre_step,
    output logic [ADDR_W-1:0] first_addr,
    output logic              first_bad,
    output logic [ADDR_W-1:0] wb_trunc
);
    logic [DATA_W-1:0] span;
    logic [DATA_W-1:0] first_full;
    logic [DATA_W-1:0] wb_full;

    // Span in bytes and the four address modes.
    always_comb begin
        span = DATA_W'(blkx_pkg::ones_in(32'(mask))) << 2;
        if (dir_up) begin
            first_full = pre_step ? base + DATA_W'(4) : base;
            wb_full    = base + span;
        end else begin
            first_full = pre_step ? base - span : base - span + DATA_W'(4);
            wb_full    = base - span;
        end
    end

    // Legality: anything above the addressable range is an exception.
    assign first_bad  = |first_full[DATA_W-1:ADDR_W];
    assign first_addr = first_full[ADDR_W-1:0];
    assign wb_trunc   = wb_full[ADDR_W-1:0];
endmodule

// File: rtl/blkx_pick.sv
// Lowest-set-bit picker: gives a one-hot of the lowest set bit of a mask
// and its binary index. Assumes the caller ignores idx for an empty mask.
module blkx_pick #(
    parameter int REGS = 16,
    localparam int IDX_W = $clog2(REGS)
) (
    input  logic [REGS-1:0]  mask,
    output logic [REGS-1:0]  low_oh,
    output logic [IDX_W-1:0] idx
);
    logic [REGS-1:0] below;

    // Prefix chain: below[i] is set when any lower bit is set.
    for (genvar i = 0; i < REGS; i++) begin : g_chain
        if (i == 0) begin : g_first
            assign below[i] = 1'b0;
        end else begin : g_rest
            assign below[i] = below[i-1] | mask[i-1];
        end
        assign low_oh[i] = mask[i] & ~below[i];
    end

    // Encode the one-hot to a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < REGS; i++)
            if (low_oh[i]) idx = idx | IDX_W'(i);
    end
endmodule

// File: rtl/blk_xfer_seq.sv
// Block transfer address sequencer top. One setup cycle, then one beat per
// set mask bit in ascending register order, plus an optional over-fetch
// beat. Writeback is strobed on the first beat. Start is ignored while busy.
// Assumes the synchronous active-low reset is held for at least one edge.
module blk_xfer_seq #(
    parameter int REGS   = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 26,
    localparam int IDX_W = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] base,
    input  logic [REGS-1:0]   reg_mask,
    input  logic              dir_up,
    input  logic              pre_step,
    input  logic              wb_en,
    input  logic              force_user,
    input  logic              cop_load,
    input  logic [IDX_W-1:0]  base_reg,
    output logic              busy,
    output logic              done,
    output logic              xfer_valid,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [IDX_W-1:0]  xfer_reg,
    output logic              xfer_discard,
    output logic              addr_exc,
    output logic              store_new_base,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_value,
    output logic              wb_user_bank
);
    import blkx_pkg::*;

    seq_state_t        state;
    logic [REGS-1:0]   mask_r;
    logic [ADDR_W-1:0] addr_r;
    logic [ADDR_W-1:0] wbv_r;
    logic              bad_r, wb_r, fu_r, cop_r, first_r;
    logic [IDX_W-1:0]  bidx_r;

    logic [ADDR_W-1:0] plan_first, plan_wb;
    logic              plan_bad;
    logic [REGS-1:0]   pick_oh;
    logic [IDX_W-1:0]  pick_idx;
    logic              last_beat;

    blkx_plan #(.REGS(REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_plan (
        .base       (base),
        .mask       (reg_mask),
        .dir_up     (dir_up),
        .pre_step   (pre_step),
        .first_addr (plan_first),
        .first_bad  (plan_bad),
        .wb_trunc   (plan_wb)
    );

    blkx_pick #(.REGS(REGS)) u_pick (
        .mask   (mask_r),
        .low_oh (pick_oh),
        .idx    (pick_idx)
    );

    assign last_beat = ((mask_r & ~pick_oh) == '0);

    // Sequencer state, operation capture and per-beat stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mask_r  <= '0;
            addr_r  <= '0;
            wbv_r   <= '0;
            bad_r   <= 1'b0;
            wb_r    <= 1'b0;
            fu_r    <= 1'b0;
            cop_r   <= 1'b0;
            first_r <= 1'b0;
            bidx_r  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_SETUP;
                    mask_r  <= reg_mask;
                    addr_r  <= plan_first;
                    wbv_r   <= plan_wb;
                    bad_r   <= plan_bad;
                    wb_r    <= wb_en;
                    fu_r    <= force_user;
                    cop_r   <= cop_load;
                    bidx_r  <= base_reg;
                    first_r <= 1'b1;
                end
                ST_SETUP: state <= (mask_r == '0) ? ST_IDLE : ST_BEAT;
                ST_BEAT: begin
                    mask_r  <= mask_r & ~pick_oh;
                    addr_r  <= addr_r + ADDR_W'(4);
                    first_r <= 1'b0;
                    if (last_beat) state <= cop_r ? ST_OVER : ST_IDLE;
                end
                ST_OVER: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port decode from the registered state.
    always_comb begin
        busy           = (state != ST_IDLE);
        xfer_valid     = (state == ST_BEAT) || (state == ST_OVER);
        xfer_discard   = (state == ST_OVER);
        xfer_addr      = addr_r;
        xfer_reg       = (state == ST_BEAT) ? pick_idx : '0;
        addr_exc       = (state == ST_BEAT) && first_r && bad_r;
        wb_valid       = (state == ST_BEAT) && first_r && wb_r;
        wb_value       = wbv_r;
        wb_user_bank   = wb_valid && fu_r;
        store_new_base = (state == ST_BEAT) && wb_r && !first_r && (pick_idx == bidx_r);
        done           = ((state == ST_SETUP) && (mask_r == '0))
                       || ((state == ST_BEAT) && last_beat && !cop_r)
                       || (state == ST_OVER);
    end

    // R1/R2: an exception appears on one beat only, never a discard beat.
    p_exc_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_exc |=> !addr_exc);
    p_exc_real_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_exc |-> (xfer_valid && !xfer_discard));
    // R3: consecutive beats of one operation step by one word, wrapping.
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !done) |=> (xfer_valid && xfer_addr == $past(xfer_addr) + ADDR_W'(4)));
    // R4: writeback lands on the beat right after the setup cycle.
    p_wb_second_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(busy) && !$past(xfer_valid)));
    // R6: register indices strictly rise within an operation.
    p_reg_ascend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_discard && !done) |=> (xfer_discard || xfer_reg > $past(xfer_reg)));
    // R9: the over-fetch beat is always the final one.
    p_discard_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_discard |-> done);
    // R8: user-bank writeback only qualifies a writeback strobe.
    p_user_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_user_bank |-> wb_valid);
endmodule

// File: tb/sim_blk_xfer_seq.sv
module sim_blk_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base = '0;
    logic [15:0] reg_mask = '0;
    logic        dir_up = 1'b0, pre_step = 1'b0, wb_en = 1'b0;
    logic        force_user = 1'b0, cop_load = 1'b0;
    logic [3:0]  base_reg = '0;
    logic        busy, done, xfer_valid, xfer_discard, addr_exc;
    logic        store_new_base, wb_valid, wb_user_bank;
    logic [25:0] xfer_addr, wb_value;
    logic [3:0]  xfer_reg;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    blk_xfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .reg_mask(reg_mask),
        .dir_up(dir_up), .pre_step(pre_step), .wb_en(wb_en), .force_user(force_user),
        .cop_load(cop_load), .base_reg(base_reg), .busy(busy), .done(done),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
        .xfer_discard(xfer_discard), .addr_exc(addr_exc), .store_new_base(store_new_base),
        .wb_valid(wb_valid), .wb_value(wb_value), .wb_user_bank(wb_user_bank)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] b, input logic [15:0] l, input bit u, input bit p,
                          input bit w, input bit f, input bit c, input logic [3:0] bi, input bit poke);
        int n;
        int k;
        logic [31:0] first32, wbx, ea;
        n = $countones(l);
        if (u) begin
            first32 = p ? b + 32'd4 : b;
            wbx = b + 32'(4 * n);
        end else begin
            first32 = p ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4;
            wbx = b - 32'(4 * n);
        end
        @(negedge clk);
        base = b; reg_mask = l; dir_up = u; pre_step = p; wb_en = w;
        force_user = f; cop_load = c; base_reg = bi; start = 1'b1;
        @(negedge clk);
        start = poke;
        if (poke) begin
            base = ~b; reg_mask = ~l; dir_up = ~u; pre_step = ~p; wb_en = ~w;
            force_user = ~f; cop_load = ~c; base_reg = ~bi;
        end
        chk(busy === 1'b1, "R4 setup busy", 32'(busy), 1);
        chk(xfer_valid === 1'b0, "R4 setup no beat", 32'(xfer_valid), 0);
        chk(done === (n == 0), "R10 setup done", 32'(done), 32'(n == 0));
        @(negedge clk);
        start = 1'b0;
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (l[i]) begin
                ea = (first32 + 32'(4 * k)) & 32'h03FF_FFFF;
                chk(xfer_valid === 1'b1 && xfer_discard === 1'b0, "R6 beat valid", 32'(xfer_valid), 1);
                chk(32'(xfer_addr) === ea, "R3 R2 beat address", 32'(xfer_addr), ea);
                chk(32'(xfer_reg) === 32'(i), "R6 register order", 32'(xfer_reg), 32'(i));
                chk(addr_exc === (k == 0 && first32 >= 32'h0400_0000), "R1 R2 exception",
                    32'(addr_exc), 32'(k == 0 && first32 >= 32'h0400_0000));
                chk(wb_valid === (k == 0 && w), "R4 writeback strobe", 32'(wb_valid), 32'(k == 0 && w));
                if (k == 0 && w) begin
                    chk(32'(wb_value) === (wbx & 32'h03FF_FFFF), "R5 writeback value",
                        32'(wb_value), wbx & 32'h03FF_FFFF);
                    chk(wb_user_bank === f, "R8 user bank", 32'(wb_user_bank), 32'(f));
                end
                chk(store_new_base === (w && i == int'(bi) && k != 0), "R7 stored base select",
                    32'(store_new_base), 32'(w && i == int'(bi) && k != 0));
                chk(done === (k == n - 1 && !c), "R6 done on last", 32'(done), 32'(k == n - 1 && !c));
                k++;
                @(negedge clk);
            end
        end
        if (c && n > 0) begin
            ea = (first32 + 32'(4 * n)) & 32'h03FF_FFFF;
            chk(xfer_valid === 1'b1 && xfer_discard === 1'b1, "R9 over-fetch beat", 32'(xfer_discard), 1);
            chk(32'(xfer_addr) === ea, "R9 over-fetch address", 32'(xfer_addr), ea);
            chk(done === 1'b1 && addr_exc === 1'b0 && wb_valid === 1'b0, "R9 over-fetch final",
                32'({done, addr_exc, wb_valid}), 32'b100);
            @(negedge clk);
        end
        chk(busy === 1'b0 && xfer_valid === 1'b0 && wb_valid === 1'b0, "R10 R11 idle after op",
            32'({busy, xfer_valid, wb_valid}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(busy === 1'b0 && xfer_valid === 1'b0 && wb_valid === 1'b0 && addr_exc === 1'b0 && done === 1'b0,
            "R12 reset state", 32'({busy, xfer_valid, wb_valid, addr_exc, done}), 0);
        rst_n = 1'b1;
        // R2: wrap of the second word; first legal
        run_op(32'h03FF_FFFC, 16'h0003, 1, 0, 1, 0, 0, 4'd9, 0);
        // R1: first address illegal
        run_op(32'h0400_0000, 16'h0003, 1, 0, 0, 0, 0, 4'd9, 0);
        // R1: descending wraps below zero, first address illegal
        run_op(32'h0000_0004, 16'h0300, 0, 1, 1, 1, 0, 4'd0, 0);
        // R7: base lowest in list keeps old value; base later takes new (0x1008)
        run_op(32'h0000_1000, 16'h0060, 1, 0, 1, 0, 0, 4'd5, 0);
        run_op(32'h0000_1000, 16'h0030, 1, 0, 1, 0, 0, 4'd5, 0);
        run_op(32'h0000_1000, 16'h0030, 1, 0, 0, 0, 0, 4'd5, 0);
        // R10: empty list, with and without over-fetch
        run_op(32'h0000_2000, 16'h0000, 1, 1, 1, 1, 1, 4'd0, 0);
        run_op(32'h0000_2000, 16'h0000, 0, 0, 1, 0, 0, 4'd0, 1);
        // R9: full list with over-fetch crossing the top of range
        run_op(32'h03FF_FFC0, 16'hFFFF, 1, 0, 1, 1, 1, 4'd15, 1);
        // R3 R6 R11: sweep of modes and masks, some with start poked while busy
        for (int m = 0; m < 8; m++) begin
            for (int i = 1; i < 81; i++) begin
                run_op(32'h0010_0000 + 32'(i * 36), 16'(i * 2741 + 3) ^ (16'(i) << 9),
                       m[0], m[1], i[0], i[1], m[2], 4'(i), (i % 5) == 0);
            end
        end
        // R6: single-bit lists
        for (int i = 0; i < 16; i++) run_op(32'h0000_0100, 16'(1) << i, 0, 0, 1, 0, i[0], 4'(i), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule